// File: doc/BRIEF.md
# External Interrupt Source Conditioning Unit

This block sits at the input side of a small interrupt controller and conditions a set of external request pins. Every pin is first brought into the clock domain through a two-stage synchronizer. A per-source configuration word then sets how the pin is read: whether the active level (or edge) is high or low, and whether the source is taken as a level or latched on an edge. An edge-sensitive source holds a pending bit until it is acknowledged or until its configuration word is rewritten.

Each source also has a destination word that steers the request to one of three outputs. It can go to the normal core interrupt, to a critical interrupt line, or to a pass-through external output. The critical and external routings apply only to level-sensitive sources; every other case uses the core path. On the core path a priority arbiter picks the highest-priority unmasked request. A read of the acknowledge word returns that source's vector, or a programmable spurious vector when nothing is pending.

Top module: `xirq_unit`

## Requirements
- R1: Word addresses for N sources: source i configuration at 2i, source i destination at 2i+1, acknowledge at 2N, spurious vector at 2N+1, routing-error status at 2N+2. Configuration fields are vector [7:0], priority [11:8], polarity [16], sense [17] and mask [31]; destination fields are external [0] and critical [1]. Every written field reads back unchanged and undefined bits read as zero.
- R2: After reset all three interrupt outputs are low, every configuration word reads 0x80000000 (masked), every destination word reads 0, status reads 0 and an acknowledge read returns the spurious reset value 0xFF.
- R3: A level-sensitive source is active while its pin equals its polarity bit (1 = high, 0 = low). Its output effect appears on the second rising clock edge after the pin changes, and not on the first.
- R4: An edge-sensitive source with polarity 1 latches a pending request on a rising pin transition, and with polarity 0 on a falling one. The opposite transition does not latch. A steady pin does not latch again, and the pending request stays after the pin returns to its inactive level.
- R5: The core interrupt output is high exactly when some core-routed, unmasked source with a request has a nonzero priority. The winner is the one with the highest priority, and among equal priorities the one with the lowest index.
- R6: A source with priority 0 never raises the core interrupt and never wins an acknowledge.
- R7: The mask bit (1 = masked) blocks a source from the core path only. A masked source routed to the critical or external output still drives that output.
- R8: An acknowledge read returns the winner's vector in bits [7:0]. The read clears the winner's pending request if it is edge-sensitive and leaves a level-sensitive source requesting.
- R9: An acknowledge read with no winner returns the spurious vector register in bits [7:0].
- R10: A level-sensitive source whose destination has only the external bit set drives the external output while active and does not reach the core output.
- R11: A level-sensitive source whose destination has only the critical bit set drives the critical output while active and does not reach the core output.
- R12: An edge-sensitive source ignores its destination bits and uses the core path.
- R13: A source with both destination bits set shows a 1 in status bit i and uses the core path only.
- R14: Writing a source's configuration word clears its pending request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_SRC | Raw external request pins |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on acknowledge only) |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_core_o | output | 1 | Normal core interrupt |
| irq_crit_o | output | 1 | Critical interrupt |
| irq_ext_o | output | 1 | Pass-through external interrupt output |

## Verification
The assertions check the following on every cycle. The outputs are quiet after reset. A fully masked set of sources never raises the core line. An idle acknowledge returns the spurious register. A pending bit rises only after a synchronized pin change, and falls only after an acknowledge read or a write to that source's configuration. Arbitration order, tie-breaking, polarity and edge direction, synchronizer latency, the routing choices and the conflict status are shown only by the bench. It sweeps priority and mask patterns and works through the edge and routing scenarios.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    parameter int PRIO_W = 4;
    parameter int VEC_W  = 8;

    // configuration word field positions
    localparam int CF_VEC_LSB   = 0;
    localparam int CF_PRIO_LSB  = 8;
    localparam int CF_POL_BIT   = 16;
    localparam int CF_SENSE_BIT = 17;
    localparam int CF_MASK_BIT  = 31;

    // destination word field positions
    localparam int DS_EXT_BIT  = 0;
    localparam int DS_CRIT_BIT = 1;

    typedef struct packed {
        logic              mask;
        logic              sense;   // 1 = level, 0 = edge
        logic              pol;     // 1 = high / rising
        logic [PRIO_W-1:0] prio;
        logic [VEC_W-1:0]  vec;
    } src_cfg_t;

    typedef struct packed {
        logic crit;
        logic ext;
    } src_dest_t;

    typedef enum logic [1:0] {
        ROUTE_CORE = 2'd0,
        ROUTE_CRIT = 2'd1,
        ROUTE_EXT  = 2'd2
    } route_e;

    localparam src_cfg_t CFG_RST = '{mask: 1'b1, sense: 1'b0, pol: 1'b0,
                                     prio: '0, vec: '0};

    function automatic src_cfg_t cfg_from_word(input logic [31:0] w);
        src_cfg_t c;
        c.vec   = w[CF_VEC_LSB +: VEC_W];
        c.prio  = w[CF_PRIO_LSB +: PRIO_W];
        c.pol   = w[CF_POL_BIT];
        c.sense = w[CF_SENSE_BIT];
        c.mask  = w[CF_MASK_BIT];
        return c;
    endfunction

    function automatic logic [31:0] cfg_to_word(input src_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[CF_VEC_LSB +: VEC_W]   = c.vec;
        w[CF_PRIO_LSB +: PRIO_W] = c.prio;
        w[CF_POL_BIT]            = c.pol;
        w[CF_SENSE_BIT]          = c.sense;
        w[CF_MASK_BIT]           = c.mask;
        return w;
    endfunction

    function automatic logic dest_conflict(input src_dest_t d);
        return d.ext & d.crit;
    endfunction

    // Side routings are honoured only for level sources with one bit set.
    function automatic route_e pick_route(input logic sense, input src_dest_t d);
        if (sense && !dest_conflict(d) && d.ext)  return ROUTE_EXT;
        if (sense && !dest_conflict(d) && d.crit) return ROUTE_CRIT;
        return ROUTE_CORE;
    endfunction

endpackage

// File: rtl/xirq_src.sv
module xirq_src (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic pol_i,
    input  logic sense_i,
    input  logic clr_i,
    output logic sync_o,
    output logic prev_o,
    output logic active_o,
    output logic pend_o
);

    logic meta_q, sync_q, prev_q, pend_q;
    logic edge_hit;

    always_comb begin
        if (sense_i)
            edge_hit = 1'b0;
        else if (pol_i)
            edge_hit = sync_q & ~prev_q;
        else
            edge_hit = ~sync_q & prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
            // a fresh edge wins over a clear in the same cycle
            if (edge_hit)
                pend_q <= 1'b1;
            else if (clr_i)
                pend_q <= 1'b0;
        end
    end

    assign active_o = pol_i ? sync_q : ~sync_q;
    assign sync_o   = sync_q;
    assign prev_o   = prev_q;
    assign pend_o   = pend_q;

endmodule

// File: rtl/xirq_route.sv
module xirq_route
    import xirq_pkg::*;
(
    input  src_cfg_t  cfg_i,
    input  src_dest_t dest_i,
    input  logic      active_i,
    input  logic      pend_i,
    output logic      core_req_o,
    output logic      crit_req_o,
    output logic      ext_req_o,
    output logic      conflict_o
);

    route_e route;
    logic   raw_req;

    always_comb begin
        route      = pick_route(cfg_i.sense, dest_i);
        raw_req    = cfg_i.sense ? active_i : pend_i;
        core_req_o = (route == ROUTE_CORE) && raw_req && !cfg_i.mask
                     && (cfg_i.prio != '0);
        crit_req_o = (route == ROUTE_CRIT) && active_i;
        ext_req_o  = (route == ROUTE_EXT) && active_i;
        conflict_o = dest_conflict(dest_i);
    end

endmodule

// File: rtl/xirq_arbiter.sv
module xirq_arbiter
    import xirq_pkg::*;
#(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]      req_i,
    input  logic [PRIO_W-1:0] prio_i [N],
    output logic              valid_o,
    output logic [IDX_W-1:0]  idx_o
);

    logic [PRIO_W-1:0] best;

    // strict greater-than keeps the lower index on a tie
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        best    = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && (!valid_o || prio_i[i] > best)) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
                best    = prio_i[i];
            end
        end
    end

endmodule

// File: rtl/xirq_unit.sv
module xirq_unit
    import xirq_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int ADDR_W  = 4,
    parameter logic [VEC_W-1:0] SPUR_RST = 8'hFF,
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pin_i,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_core_o,
    output logic               irq_crit_o,
    output logic               irq_ext_o
);

    localparam logic [ADDR_W-1:0] ACK_A  = ADDR_W'(2 * NUM_SRC);
    localparam logic [ADDR_W-1:0] SPUR_A = ADDR_W'(2 * NUM_SRC + 1);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(2 * NUM_SRC + 2);

    src_cfg_t          cfg_q  [NUM_SRC];
    src_dest_t         dest_q [NUM_SRC];
    logic [VEC_W-1:0]  spur_q;

    logic [NUM_SRC-1:0] cfg_wr, clr, core_req, crit_req, ext_req, conflict;
    logic [NUM_SRC-1:0] mask_vec, sync_vec, prev_vec, pend_vec, active_vec;
    logic [PRIO_W-1:0]  prio_v [NUM_SRC];
    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;
    logic               ack_rd;

    assign ack_rd = bus_rd && (bus_addr == ACK_A);

    // register file
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                cfg_q[i]  <= CFG_RST;
                dest_q[i] <= '0;
            end
            spur_q <= SPUR_RST;
        end else if (bus_wr) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (bus_addr == ADDR_W'(2 * i))
                    cfg_q[i] <= cfg_from_word(bus_wdata);
                if (bus_addr == ADDR_W'(2 * i + 1))
                    dest_q[i] <= '{crit: bus_wdata[DS_CRIT_BIT],
                                   ext:  bus_wdata[DS_EXT_BIT]};
            end
            if (bus_addr == SPUR_A)
                spur_q <= bus_wdata[VEC_W-1:0];
        end
    end

    // per-source conditioning and routing
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign cfg_wr[g]   = bus_wr && (bus_addr == ADDR_W'(2 * g));
        assign clr[g]      = cfg_wr[g] ||
                             (ack_rd && win_valid && (win_idx == IDX_W'(g)));
        assign mask_vec[g] = cfg_q[g].mask;
        assign prio_v[g]   = cfg_q[g].prio;

        xirq_src i_src (
            .clk      (clk),
            .rst      (rst),
            .pin_i    (pin_i[g]),
            .pol_i    (cfg_q[g].pol),
            .sense_i  (cfg_q[g].sense),
            .clr_i    (clr[g]),
            .sync_o   (sync_vec[g]),
            .prev_o   (prev_vec[g]),
            .active_o (active_vec[g]),
            .pend_o   (pend_vec[g])
        );

        xirq_route i_route (
            .cfg_i      (cfg_q[g]),
            .dest_i     (dest_q[g]),
            .active_i   (active_vec[g]),
            .pend_i     (pend_vec[g]),
            .core_req_o (core_req[g]),
            .crit_req_o (crit_req[g]),
            .ext_req_o  (ext_req[g]),
            .conflict_o (conflict[g])
        );
    end

    xirq_arbiter #(.N(NUM_SRC)) i_arb (
        .req_i   (core_req),
        .prio_i  (prio_v),
        .valid_o (win_valid),
        .idx_o   (win_idx)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (bus_addr == ADDR_W'(2 * i))
                bus_rdata = cfg_to_word(cfg_q[i]);
            if (bus_addr == ADDR_W'(2 * i + 1))
                bus_rdata = 32'({dest_q[i].crit, dest_q[i].ext});
        end
        if (bus_addr == ACK_A)
            bus_rdata = win_valid ? 32'(cfg_q[win_idx].vec) : 32'(spur_q);
        if (bus_addr == SPUR_A)
            bus_rdata = 32'(spur_q);
        if (bus_addr == STAT_A)
            bus_rdata = 32'(conflict);
    end

    assign irq_core_o = win_valid;
    assign irq_crit_o = |crit_req;
    assign irq_ext_o  = |ext_req;

endmodule

// File: rtl/xirq_checker.sv
module xirq_checker
    import xirq_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_rdata,
    input logic               irq_core_o,
    input logic               irq_crit_o,
    input logic               irq_ext_o,
    input logic [VEC_W-1:0]   spur_q,
    input logic [NUM_SRC-1:0] mask_vec,
    input logic [NUM_SRC-1:0] sync_vec,
    input logic [NUM_SRC-1:0] prev_vec,
    input logic [NUM_SRC-1:0] pend_vec
);

    localparam logic [ADDR_W-1:0] ACK_A = ADDR_W'(2 * NUM_SRC);

    p_reset_quiet_r2: assert property (@(posedge clk)
        rst |=> (!irq_core_o && !irq_crit_o && !irq_ext_o));

    p_mask_all_r7: assert property (@(posedge clk) disable iff (rst)
        (&mask_vec) |-> !irq_core_o);

    p_spurious_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ACK_A && !irq_core_o) |-> (bus_rdata == 32'(spur_q)));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        p_pend_rise_r4: assert property (@(posedge clk) disable iff (rst)
            $rose(pend_vec[g]) |-> $past(sync_vec[g] != prev_vec[g]));

        // R8 and R14: only an acknowledge or a config write drops a pending bit
        p_pend_fall_r8: assert property (@(posedge clk) disable iff (rst)
            $fell(pend_vec[g]) |->
                $past((bus_rd && bus_addr == ACK_A) ||
                      (bus_wr && bus_addr == ADDR_W'(2 * g))));
    end

endmodule

bind xirq_unit xirq_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_xirq_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .irq_core_o (irq_core_o),
    .irq_crit_o (irq_crit_o),
    .irq_ext_o  (irq_ext_o),
    .spur_q     (spur_q),
    .mask_vec   (mask_vec),
    .sync_vec   (sync_vec),
    .prev_vec   (prev_vec),
    .pend_vec   (pend_vec)
);

// File: tb/test_xirq_unit.sv
`timescale 1ns/1ps
module test_xirq_unit;

    localparam int N  = 4;
    localparam int AW = 4;
    localparam logic [AW-1:0] ACK  = 4'd8;
    localparam logic [AW-1:0] SPUR = 4'd9;
    localparam logic [AW-1:0] STAT = 4'd10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  pins = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_core_o, irq_crit_o, irq_ext_o;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    xirq_unit #(.NUM_SRC(N), .ADDR_W(AW)) i_xirq_unit (
        .clk        (clk),
        .rst        (rst),
        .pin_i      (pins),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_core_o (irq_core_o),
        .irq_crit_o (irq_crit_o),
        .irq_ext_o  (irq_ext_o)
    );

    function automatic logic [31:0] cw(input logic [7:0] vec, input int prio,
                                       input logic pol, input logic sense,
                                       input logic mask);
        return (32'(mask) << 31) | (32'(sense) << 17) | (32'(pol) << 16)
             | (32'(prio & 15) << 8) | 32'(vec);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic clear_all();
        pins = '0;
        settle();
        for (int i = 0; i < N; i++) begin
            wr(AW'(2 * i), 32'h8000_0000);
            wr(AW'(2 * i + 1), 32'h0);
        end
    endtask

    task automatic outs(input string tag, input logic c, input logic k, input logic e);
        chk(tag, {29'd0, irq_core_o, irq_crit_o, irq_ext_o}, {29'd0, c, k, e});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R2 reset state
        outs("R2 outputs", 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < N; i++) begin
            rd(AW'(2 * i), d);     chk("R2 cfg reset", d, 32'h8000_0000);
            rd(AW'(2 * i + 1), d); chk("R2 dest reset", d, 32'h0);
        end
        rd(STAT, d); chk("R2 status", d, 32'h0);
        rd(ACK, d);  chk("R2 spurious reset", d, 32'hFF);

        // R1 readback
        for (int i = 0; i < N; i++) begin
            wr(AW'(2 * i), cw(8'h5A + 8'(i), i + 9, i[0], i[1], 1'b1) | 32'h7FFC_F000);
            rd(AW'(2 * i), d);
            chk("R1 cfg readback", d, cw(8'h5A + 8'(i), i + 9, i[0], i[1], 1'b1));
            wr(AW'(2 * i + 1), 32'hFFFF_FFFC | 32'(i));
            rd(AW'(2 * i + 1), d);
            chk("R1 dest readback", d, 32'(i));
        end
        wr(SPUR, 32'h0000_0177);
        rd(SPUR, d); chk("R1 spurious readback", d, 32'h77);
        wr(SPUR, 32'hFF);

        // R3 level polarity and latency
        for (int i = 0; i < N; i++) begin
            for (int p = 0; p < 2; p++) begin
                clear_all();
                pins[i] = ~p[0];
                settle();
                wr(AW'(2 * i), cw(8'h20 + 8'(i), 3, p[0], 1'b1, 1'b0));
                outs("R3 inactive", 1'b0, 1'b0, 1'b0);
                @(negedge clk) pins[i] = p[0];
                @(posedge clk); #1;
                outs("R3 one edge", 1'b0, 1'b0, 1'b0);
                @(posedge clk); #1;
                outs("R3 two edges", 1'b1, 1'b0, 1'b0);
                rd(ACK, d); chk("R3 vector", d, 32'h20 + 32'(i));
                @(negedge clk) pins[i] = ~p[0];
                settle();
                outs("R3 released", 1'b0, 1'b0, 1'b0);
            end
        end

        // R4 / R8 / R14 edge behaviour
        for (int i = 0; i < N; i++) begin
            for (int p = 0; p < 2; p++) begin
                clear_all();
                pins[i] = ~p[0];
                settle();
                wr(AW'(2 * i), cw(8'h30 + 8'(i), 4, p[0], 1'b0, 1'b0));
                outs("R4 idle", 1'b0, 1'b0, 1'b0);
                pins[i] = p[0]; settle();
                outs("R4 active edge", 1'b1, 1'b0, 1'b0);
                rd(ACK, d); chk("R8 edge vector", d, 32'h30 + 32'(i));
                outs("R8 pending cleared", 1'b0, 1'b0, 1'b0);
                settle();
                outs("R4 steady no retrigger", 1'b0, 1'b0, 1'b0);
                pins[i] = ~p[0]; settle();
                outs("R4 opposite edge ignored", 1'b0, 1'b0, 1'b0);
                pins[i] = p[0]; settle();
                pins[i] = ~p[0]; settle();
                outs("R4 latched after release", 1'b1, 1'b0, 1'b0);
                wr(AW'(2 * i), cw(8'h30 + 8'(i), 4, p[0], 1'b0, 1'b0));
                outs("R14 cfg write clears", 1'b0, 1'b0, 1'b0);
            end
        end

        // R5 / R6 priority sweep, all level sources active
        clear_all();
        pins = '1; settle();
        for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
        for (int e = 0; e < 4; e++) begin
            int pr [N];
            int best, win;
            pr[0] = a; pr[1] = b; pr[2] = c; pr[3] = e;
            best = 0; win = -1;
            for (int i = 0; i < N; i++) begin
                wr(AW'(2 * i), cw(8'h10 + 8'(i), pr[i], 1'b1, 1'b1, 1'b0));
                if (pr[i] > best) begin best = pr[i]; win = i; end
            end
            chk("R6/R5 core line", 32'(irq_core_o), 32'(win >= 0));
            rd(ACK, d);
            chk("R5 winner vector", d, (win >= 0) ? 32'h10 + 32'(win) : 32'hFF);
        end

        // R7 mask sweep
        for (int m = 0; m < 16; m++) begin
            int win;
            win = -1;
            for (int i = 0; i < N; i++) begin
                wr(AW'(2 * i), cw(8'h10 + 8'(i), i + 1, 1'b1, 1'b1, m[i]));
                if (!m[i]) win = i;
            end
            rd(ACK, d);
            chk("R7 masked winner", d, (win >= 0) ? 32'h10 + 32'(win) : 32'hFF);
        end
        // masked source with a critical route still drives it
        wr(AW'(1), 32'h2);
        outs("R7 mask spares critical", 1'b0, 1'b1, 1'b0);

        // R8 acknowledge order, R9 spurious
        clear_all();
        wr(AW'(2), cw(8'h41, 7, 1'b1, 1'b0, 1'b0));
        wr(AW'(4), cw(8'h42, 9, 1'b1, 1'b0, 1'b0));
        wr(AW'(6), cw(8'h43, 2, 1'b1, 1'b1, 1'b0));
        pins = 4'b1110; settle();
        rd(ACK, d); chk("R8 first ack", d, 32'h42);
        rd(ACK, d); chk("R8 second ack", d, 32'h41);
        rd(ACK, d); chk("R8 level stays", d, 32'h43);
        rd(ACK, d); chk("R8 level stays again", d, 32'h43);
        outs("R8 level still asserted", 1'b1, 1'b0, 1'b0);
        clear_all();
        wr(SPUR, 32'h3C);
        rd(ACK, d); chk("R9 spurious vector", d, 32'h3C);

        // R10 / R11 / R13 routing
        clear_all();
        wr(AW'(2), cw(8'h51, 5, 1'b1, 1'b1, 1'b0));
        wr(AW'(3), 32'h1);
        pins[1] = 1'b1; settle();
        outs("R10 external route", 1'b0, 1'b0, 1'b1);
        wr(AW'(3), 32'h2);
        outs("R11 critical route", 1'b0, 1'b1, 1'b0);
        pins[1] = 1'b0; settle();
        outs("R11 critical released", 1'b0, 1'b0, 1'b0);
        wr(AW'(3), 32'h3);
        pins[1] = 1'b1; settle();
        outs("R13 conflict to core", 1'b1, 1'b0, 1'b0);
        rd(STAT, d); chk("R13 status bit", d, 32'h2);
        wr(AW'(3), 32'h0);
        rd(STAT, d); chk("R13 status cleared", d, 32'h0);

        // R12 edge source ignores destination
        clear_all();
        wr(AW'(4), cw(8'h62, 6, 1'b1, 1'b0, 1'b0));
        wr(AW'(5), 32'h2);
        pins[2] = 1'b1; settle();
        outs("R12 edge uses core", 1'b1, 1'b0, 1'b0);
        rd(ACK, d); chk("R12 edge vector", d, 32'h62);
        wr(AW'(5), 32'h1);
        pins[2] = 1'b0; settle();
        pins[2] = 1'b1; settle();
        outs("R12 edge ignores external", 1'b1, 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule